// File: doc/BRIEF.md
# ADC Sample Pair Packer

This block sits in the conversion clock domain, between a pipelined 12-bit converter and the write side of a dual-clock FIFO. Each converted sample and its overflow flag go into a 16-bit lane. Two consecutive samples are joined into one 32-bit word, and one FIFO write is issued for every second conversion. The FIFO write port shares the conversion clock, so the block issues a plain synchronous write enable. It also drives an active-low output enable that presents the packed word on the data bus during the write.

The block drives the converter's clock enable. After acquisition is switched on, it ignores the first few outputs of the converter pipeline, so no stale samples are packed. If the FIFO reports full when a word is due, that word is discarded and a sticky overrun flag is raised. When acquisition is switched off, the pair position is cleared, so the next captured sample always opens a new word in the low lane.

Top module: `adc_pair_packer`

## Requirements
- R1: `conv_en` is a registered copy of `acq_en`: it equals the value `acq_en` had at the previous rising clock edge.
- R2: Counting from the first cycle in which `conv_en` is high, no capture strobe is asserted during the first `LATENCY` cycles (default 3). The first strobe comes in cycle `LATENCY`+1, provided `conv_en` stays high.
- R3: Once captures start, a strobe is asserted in every cycle that `conv_en` stays high. The strobes alternate, low lane first and then high lane, and the two are never asserted together.
- R4: Each lane holds the 12-bit code in bits 11:0 and the overflow flag in bit 12, with bits 15:13 at zero. The first sample of a pair occupies `fifo_data[15:0]` and the second occupies `fifo_data[31:16]`.
- R5: `fifo_we` is high for exactly one cycle: the cycle after a high-lane strobe, provided `fifo_full` is low in that cycle. No write takes place at any other time.
- R6: `oe_n` is low exactly when `fifo_we` is high. While `oe_n` is high, `fifo_data` is all zeros.
- R7: If `fifo_full` is high in the cycle after a high-lane strobe, no write takes place, that pair is never written, and `overrun` is high from the next cycle on.
- R8: `overrun` stays high until a cycle in which `ovr_clr` is high, and clears at the next edge. A new drop in that same cycle keeps it set.
- R9: A cycle with `conv_en` low resets the pair position, so the first capture after re-enabling always uses the low lane.
- R10: While `rst` is asserted and after its release, with `acq_en` low, all outputs are low except `oe_n`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; also clocks the FIFO write port |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition enable |
| adc_code | input | 12 | Converter output sample |
| adc_ovf | input | 1 | Converter overflow flag for this sample |
| fifo_full | input | 1 | FIFO full indication |
| ovr_clr | input | 1 | Synchronous clear of the overrun flag |
| conv_en | output | 1 | Conversion clock enable to the converter |
| cap_lo_stb | output | 1 | Low-lane capture strobe |
| cap_hi_stb | output | 1 | High-lane capture strobe |
| oe_n | output | 1 | Active-low output enable of the packed word |
| fifo_we | output | 1 | FIFO write enable |
| fifo_data | output | 32 | Packed word, zero while not enabled |
| overrun | output | 1 | Sticky flag: a pair was dropped because the FIFO was full |

## Verification
The bench sweeps every combination of short enable-off and enable-on runs. This catches a latency gate that is off by one cycle, which would pack a stale sample or lose the first good one. It also catches a pair position that survives a disable, which would put a fresh sample in the high lane next to an old one. Pseudo-random full and clear patterns test that a dropped pair never reappears as a late write. They also test that the overrun flag neither clears by itself nor loses a drop that coincides with a clear. Varied codes with sparse overflow flags show lane swaps and a misplaced flag bit as wrong data words.

// File: rtl/pk_pkg.sv
package pk_pkg;
    localparam int SAMPLE_W = 12;
    localparam int LANE_W   = 16;
    localparam int PAD_W    = LANE_W - SAMPLE_W - 1;
    localparam int LANES    = 2;
    localparam int WORD_W   = LANES * LANE_W;

    typedef struct packed {
        logic [PAD_W-1:0]    pad;
        logic                ovf;
        logic [SAMPLE_W-1:0] code;
    } lane_t;

    typedef struct packed {
        lane_t hi;
        lane_t lo;
    } word_t;

    function automatic lane_t make_lane(input logic [SAMPLE_W-1:0] c, input logic o);
        lane_t l;
        l.pad  = '0;
        l.ovf  = o;
        l.code = c;
        return l;
    endfunction
endpackage

// File: rtl/pk_latency_gate.sv
module pk_latency_gate #(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic acq_en,
    output logic conv_en,
    output logic sample_ok
);
    localparam int LAT_W = $clog2(LATENCY + 2);

    logic [LAT_W-1:0] warm_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_en  <= 1'b0;
            warm_cnt <= '0;
        end else begin
            conv_en <= acq_en;
            if (!conv_en)
                warm_cnt <= '0;
            else if (warm_cnt != LAT_W'(LATENCY))
                warm_cnt <= warm_cnt + 1'b1;
        end
    end

    assign sample_ok = conv_en && (warm_cnt == LAT_W'(LATENCY));

    // R1
    conv_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (conv_en == $past(acq_en)));

    generate
        if (LATENCY > 0) begin : g_hold
            // R2
            gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(conv_en) |-> !sample_ok);
        end
    endgenerate
endmodule

// File: rtl/pk_lane_capture.sv
module pk_lane_capture
    import pk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_en,
    input  logic                sample_ok,
    input  logic [SAMPLE_W-1:0] adc_code,
    input  logic                adc_ovf,
    output logic                cap_lo_stb,
    output logic                cap_hi_stb,
    output logic                pair_done,
    output word_t               word
);
    logic              phase;
    logic [LANES-1:0]  stb;
    lane_t             lane_w [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            lane_t q;
            assign stb[g] = sample_ok && (phase == 1'(g));
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (stb[g])
                    q <= make_lane(adc_code, adc_ovf);
            end
            assign lane_w[g] = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !conv_en)
            phase <= 1'b0;
        else if (sample_ok)
            phase <= ~phase;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pair_done <= 1'b0;
        else
            pair_done <= stb[LANES-1];
    end

    assign cap_lo_stb = stb[0];
    assign cap_hi_stb = stb[LANES-1];
    assign word.lo    = lane_w[0];
    assign word.hi    = lane_w[LANES-1];

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cap_lo_stb && cap_hi_stb));

    // R3
    hi_follows_lo_chk: assert property (@(posedge clk) disable iff (rst)
        cap_hi_stb |-> $past(cap_lo_stb));
endmodule

// File: rtl/pk_write_ctrl.sv
module pk_write_ctrl
    import pk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_done,
    input  logic              fifo_full,
    input  logic              ovr_clr,
    input  word_t             word,
    output logic              fifo_we,
    output logic              oe_n,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overrun
);
    logic drop;

    assign drop      = pair_done && fifo_full;
    assign fifo_we   = pair_done && !fifo_full;
    assign oe_n      = !fifo_we;
    assign fifo_data = fifo_we ? WORD_W'(word) : '0;

    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (drop)
            overrun <= 1'b1;
        else if (ovr_clr)
            overrun <= 1'b0;
    end

    // R7
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> overrun);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/adc_pair_packer.sv
module adc_pair_packer
    import pk_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_en,
    input  logic [11:0]       adc_code,
    input  logic              adc_ovf,
    input  logic              fifo_full,
    input  logic              ovr_clr,
    output logic              conv_en,
    output logic              cap_lo_stb,
    output logic              cap_hi_stb,
    output logic              oe_n,
    output logic              fifo_we,
    output logic [31:0]       fifo_data,
    output logic              overrun
);
    logic  sample_ok;
    logic  pair_done;
    word_t word;

    pk_latency_gate #(.LATENCY(LATENCY)) i_gate (
        .clk       (clk),
        .rst       (rst),
        .acq_en    (acq_en),
        .conv_en   (conv_en),
        .sample_ok (sample_ok)
    );

    pk_lane_capture i_cap (
        .clk        (clk),
        .rst        (rst),
        .conv_en    (conv_en),
        .sample_ok  (sample_ok),
        .adc_code   (adc_code),
        .adc_ovf    (adc_ovf),
        .cap_lo_stb (cap_lo_stb),
        .cap_hi_stb (cap_hi_stb),
        .pair_done  (pair_done),
        .word       (word)
    );

    pk_write_ctrl i_wr (
        .clk       (clk),
        .rst       (rst),
        .pair_done (pair_done),
        .fifo_full (fifo_full),
        .ovr_clr   (ovr_clr),
        .word      (word),
        .fifo_we   (fifo_we),
        .oe_n      (oe_n),
        .fifo_data (fifo_data),
        .overrun   (overrun)
    );

    // R5
    we_after_hi_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> $past(cap_hi_stb));

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (fifo_data[31:29] == 3'b000 && fifo_data[15:13] == 3'b000));
endmodule

// File: tb/test_adc_pair_packer.sv
module test_adc_pair_packer;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_en = 1'b0;
    logic [11:0] adc_code = '0;
    logic        adc_ovf = 1'b0;
    logic        fifo_full = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        conv_en, cap_lo_stb, cap_hi_stb, oe_n, fifo_we, overrun;
    logic [31:0] fifo_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int sidx   = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference state, built from the requirements
    logic        m_conv = 0, m_ph = 0, m_rdy = 0, m_ovr = 0;
    int          m_lat = 0;
    logic [15:0] m_lo = 0, m_hi = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pair_packer #(.LATENCY(LAT)) i_adc_pair_packer (
        .clk(clk), .rst(rst), .acq_en(acq_en), .adc_code(adc_code), .adc_ovf(adc_ovf),
        .fifo_full(fifo_full), .ovr_clr(ovr_clr), .conv_en(conv_en),
        .cap_lo_stb(cap_lo_stb), .cap_hi_stb(cap_hi_stb), .oe_n(oe_n),
        .fifo_we(fifo_we), .fifo_data(fifo_data), .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    task automatic step(input logic a, input logic full, input logic clr);
        logic        valid, e_lo, e_hi, e_we;
        logic [15:0] lane;
        @(negedge clk);
        acq_en    = a;
        fifo_full = full;
        ovr_clr   = clr;
        adc_code  = 12'((sidx * 149 + 7) & 12'hFFF);
        adc_ovf   = (sidx % 5 == 0);
        sidx++;
        #1;
        lane  = {3'b000, adc_ovf, adc_code};
        valid = m_conv && (m_lat == LAT);
        e_lo  = valid && !m_ph;
        e_hi  = valid && m_ph;
        e_we  = m_rdy && !full;
        check("R1 conv_en", {31'd0, conv_en}, {31'd0, m_conv});
        check((m_conv && m_lat < LAT) ? "R2 lo strobe during warm-up" : "R9 lo strobe",
              {31'd0, cap_lo_stb}, {31'd0, e_lo});
        check("R3 hi strobe", {31'd0, cap_hi_stb}, {31'd0, e_hi});
        check(full ? "R7 write while full" : "R5 write enable", {31'd0, fifo_we}, {31'd0, e_we});
        check("R6 oe_n", {31'd0, oe_n}, {31'd0, !e_we});
        check(e_we ? "R4 packed word" : "R6 idle data", fifo_data, e_we ? {m_hi, m_lo} : 32'd0);
        check("R8 overrun", {31'd0, overrun}, {31'd0, m_ovr});
        @(posedge clk);
        if (m_rdy && full) m_ovr = 1'b1;
        else if (clr)      m_ovr = 1'b0;
        m_rdy = e_hi;
        if (e_lo) m_lo = lane;
        if (e_hi) m_hi = lane;
        if (!m_conv) begin
            m_lat = 0;
            m_ph  = 1'b0;
        end else begin
            if (m_lat != LAT) m_lat++;
            if (valid) m_ph = ~m_ph;
        end
        m_conv = a;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs while held in reset
        check("R10 reset conv_en", {31'd0, conv_en}, 32'd0);
        check("R10 reset strobes", {30'd0, cap_lo_stb, cap_hi_stb}, 32'd0);
        check("R10 reset we/oe_n", {30'd0, fifo_we, oe_n}, 32'd1);
        check("R10 reset data", fifo_data, 32'd0);
        check("R10 reset overrun", {31'd0, overrun}, 32'd0);
        rst = 1'b0;

        repeat (6)  step(1'b0, 1'b0, 1'b0);
        // continuous run, R2 and R3 timing, R4 packing
        repeat (30) step(1'b1, 1'b0, 1'b0);
        // stop after a low-lane capture only, then resume: R9
        repeat (2)  step(1'b0, 1'b0, 1'b0);
        repeat (LAT + 2) step(1'b1, 1'b0, 1'b0);
        repeat (2)  step(1'b0, 1'b0, 1'b0);
        repeat (12) step(1'b1, 1'b0, 1'b0);
        // FIFO held full, then clear: R7 and R8
        repeat (12) step(1'b1, 1'b1, 1'b0);
        repeat (6)  step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        repeat (6)  step(1'b1, 1'b0, 1'b0);

        // exhaustive off/on run lengths
        for (int off = 1; off <= 4; off++) begin
            for (int on = 1; on <= 10; on++) begin
                repeat (off) step(1'b0, 1'b0, 1'b0);
                repeat (on)  step(1'b1, 1'b0, 1'b0);
            end
        end

        // pseudo-random full, clear and enable patterns
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:3] != 5'd0, lfsr[1:0] == 2'b00, lfsr[11:8] == 4'hF);
        end
        repeat (4) step(1'b0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule